// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block produces the two active-low DMA request lines of one UART channel: one that asks a DMA engine to empty the receive side, and one that asks it to fill the transmit side. It does not hold any characters itself. The receive and transmit storage report their occupancy as counts, and the receiver adds two event flags: the programmed trigger level has been reached, and a character timeout has occurred. From these inputs and a small control word, the block decides when each request line is driven low.

The control word holds two bits: a FIFO-enable bit and a multi-transfer select bit. Multi-transfer signalling is used only when both bits are set. In every other case the block uses single-transfer signalling. This includes the legacy case, in which each direction holds only one character.

In single-transfer signalling, each request follows occupancy directly. In multi-transfer signalling, the two requests are held and released on deliberately different conditions. The receive request starts on a trigger or timeout event and is held until the receive side has fully drained. The transmit request starts when the transmit side is empty and is held until that side is full. Both request lines are registered outputs.

Top module: `uart_dma_req`

## Requirements
- R1: During and directly after a synchronous reset, both request outputs are high, the FIFO-enable bit is cleared and the multi-transfer select bit is cleared.
- R2: While the stored FIFO-enable bit is 0, both outputs follow single-transfer rules, whatever the multi-transfer select bit holds. In this legacy case the transmit side counts as full at 1 character.
- R3: In single-transfer signalling, `rx_rdy_n` is 0 after an edge at which `rx_count` was nonzero, and 1 after an edge at which it was 0.
- R4: In multi-transfer signalling, `rx_rdy_n` goes to 0 after an edge at which `rx_count` was nonzero and either `rx_trig_hit` or `rx_timeout` was 1.
- R5: In multi-transfer signalling, once `rx_rdy_n` is 0 it stays 0, even with both event flags low, until an edge at which `rx_count` is 0. After that edge it is 1. A zero count overrides any event flag.
- R6: In single-transfer signalling, `tx_rdy_n` is 0 after an edge at which `tx_count` was 0, and 1 otherwise.
- R7: In multi-transfer signalling, `tx_rdy_n` goes to 0 after an edge at which `tx_count` was 0, and goes to 1 after an edge at which `tx_count` was at least DEPTH. For counts in between it keeps its previous value.
- R8: Multi-transfer signalling is in effect only when both the FIFO-enable bit and the select bit are 1.
- R9: A control write (`cfg_wr`=1) updates both control bits at that edge. At the same edge, both outputs are recomputed under the new mode from the current inputs. Both held multi-transfer requests start released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load the control word this cycle |
| cfg_fifo_on | input | 1 | New FIFO-enable bit |
| cfg_multi_sel | input | 1 | New multi-transfer select bit |
| rx_count | input | $clog2(DEPTH+1) | Characters held on the receive side |
| rx_trig_hit | input | 1 | Receive trigger level reached |
| rx_timeout | input | 1 | Receive character timeout |
| tx_count | input | $clog2(DEPTH+1) | Characters held on the transmit side |
| rx_rdy_n | output | 1 | Receive DMA request, active low |
| tx_rdy_n | output | 1 | Transmit DMA request, active low |

## Verification
The assertions assume that occupancy counts never exceed DEPTH. They also assume that in legacy mode the counts stay at 0 or 1, as a single holding register would report. The event flags are treated as independent of the count, so a trigger that arrives with an empty receive side must lose to the drain rule. The stimulus keeps every count within 0..DEPTH and gives legacy phases only 0 or 1. It raises the flags freely, including with zero occupancy. Mode changes are issued in the middle of held requests, to exercise the re-evaluation rule.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

    typedef enum logic {
        DMA_SINGLE = 1'b0,
        DMA_MULTI  = 1'b1
    } dma_mode_e;

    typedef struct packed {
        logic fifo_on;
        logic multi_sel;
    } dma_ctrl_t;

    localparam dma_ctrl_t CTRL_RESET = '{fifo_on: 1'b0, multi_sel: 1'b0};

    // Multi-transfer needs FIFO operation; legacy mode falls back to single.
    function automatic dma_mode_e mode_of(dma_ctrl_t c);
        return (c.fifo_on && c.multi_sel) ? DMA_MULTI : DMA_SINGLE;
    endfunction

endpackage

// File: rtl/uart_dma_cfg.sv
module uart_dma_cfg
    import uart_dma_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  logic      fifo_on,
    input  logic      multi_sel,
    output dma_mode_e mode_next,
    output logic      reeval
);
    dma_ctrl_t ctrl_q;
    dma_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            ctrl_d.fifo_on   = fifo_on;
            ctrl_d.multi_sel = multi_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= CTRL_RESET;
        else     ctrl_q <= ctrl_d;
    end

    assign mode_next = mode_of(ctrl_d);
    assign reeval    = wr;

    AST_LEGACY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.fifo_on && !wr) |-> (mode_next == DMA_SINGLE)); // R2

endmodule

// File: rtl/uart_dma_rx_req.sv
module uart_dma_rx_req
    import uart_dma_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  dma_mode_e     mode,
    input  logic          reeval,
    input  logic [CW-1:0] count,
    input  logic          trig,
    input  logic          tmo,
    output logic          req
);
    logic req_d;
    logic held;

    always_comb begin
        held = req & ~reeval;
        if (mode == DMA_SINGLE)  req_d = (count != '0);
        else if (count == '0)    req_d = 1'b0;
        else if (trig || tmo)    req_d = 1'b1;
        else                     req_d = held;
    end

    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= req_d;
    end

    AST_RX_SINGLE_TRACK: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == DMA_SINGLE && !$past(rst)) |-> (req == ($past(count) != '0))); // R3
    AST_RX_MULTI_START: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == DMA_MULTI && $past(count) != '0 && ($past(trig) || $past(tmo)) && !$past(rst)) |-> req); // R4
    AST_RX_DRAIN_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ($past(count) == '0) |-> !req); // R5
    AST_RX_MULTI_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == DMA_MULTI && $past(req) && !$past(reeval) && $past(count) != '0 && !$past(rst)) |-> req); // R5

endmodule

// File: rtl/uart_dma_tx_req.sv
module uart_dma_tx_req
    import uart_dma_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  dma_mode_e     mode,
    input  logic          reeval,
    input  logic [CW-1:0] count,
    output logic          req
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic req_d;
    logic held;

    always_comb begin
        held = req & ~reeval;
        if (mode == DMA_SINGLE)    req_d = (count == '0);
        else if (count == '0)      req_d = 1'b1;
        else if (count >= FULL_LVL) req_d = 1'b0;
        else                       req_d = held;
    end

    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= req_d;
    end

    AST_TX_EMPTY_ASKS: assert property (@(posedge clk) disable iff (rst)
        ($past(count) == '0 && !$past(rst)) |-> req); // R6
    AST_TX_FULL_STOPS: assert property (@(posedge clk) disable iff (rst)
        ($past(count) >= FULL_LVL) |-> !req); // R7
    AST_TX_MULTI_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == DMA_MULTI && !$past(reeval) && $past(count) != '0
         && $past(count) < FULL_LVL && !$past(rst)) |-> (req == $past(req))); // R7

endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req
    import uart_dma_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic          cfg_fifo_on,
    input  logic          cfg_multi_sel,
    input  logic [CW-1:0] rx_count,
    input  logic          rx_trig_hit,
    input  logic          rx_timeout,
    input  logic [CW-1:0] tx_count,
    output logic          rx_rdy_n,
    output logic          tx_rdy_n
);
    dma_mode_e mode_next;
    logic      reeval;
    logic      rx_req;
    logic      tx_req;

    uart_dma_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr        (cfg_wr),
        .fifo_on   (cfg_fifo_on),
        .multi_sel (cfg_multi_sel),
        .mode_next (mode_next),
        .reeval    (reeval)
    );

    uart_dma_rx_req #(.CW(CW)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode_next),
        .reeval (reeval),
        .count  (rx_count),
        .trig   (rx_trig_hit),
        .tmo    (rx_timeout),
        .req    (rx_req)
    );

    uart_dma_tx_req #(.DEPTH(DEPTH), .CW(CW)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode_next),
        .reeval (reeval),
        .count  (tx_count),
        .req    (tx_req)
    );

    assign rx_rdy_n = ~rx_req;
    assign tx_rdy_n = ~tx_req;

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (rx_rdy_n && tx_rdy_n)); // R1
    AST_MULTI_NEEDS_FIFO: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cfg_fifo_on && rx_count == '0) |=> rx_rdy_n); // R8

endmodule

// File: tb/uart_dma_req_test.sv
module uart_dma_req_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic          cfg_fifo_on = 1'b0;
    logic          cfg_multi_sel = 1'b0;
    logic [CW-1:0] rx_count = '0;
    logic          rx_trig_hit = 1'b0;
    logic          rx_timeout = 1'b0;
    logic [CW-1:0] tx_count = '0;
    logic          rx_rdy_n;
    logic          tx_rdy_n;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    int  m_fifo = 0;
    int  m_sel  = 0;
    bit  m_rx   = 0;
    bit  m_tx   = 0;
    bit  m_multi_last = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_dma_req #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_fifo_on(cfg_fifo_on),
        .cfg_multi_sel(cfg_multi_sel), .rx_count(rx_count), .rx_trig_hit(rx_trig_hit),
        .rx_timeout(rx_timeout), .tx_count(tx_count), .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n)
    );

    always @(posedge clk) begin
        int fe, sl, rc, tc;
        bit multi, fresh;
        if (rst) begin
            m_fifo = 0; m_sel = 0; m_rx = 0; m_tx = 0; m_multi_last = 0;
        end else begin
            fresh = cfg_wr;
            if (cfg_wr) begin
                m_fifo = int'(cfg_fifo_on); m_sel = int'(cfg_multi_sel);
            end
            fe = m_fifo; sl = m_sel;
            multi = (fe == 1 && sl == 1);
            rc = int'(rx_count); tc = int'(tx_count);
            if (fresh) begin m_rx = 0; m_tx = 0; end
            if (!multi) begin
                m_rx = (rc > 0);
                m_tx = (tc == 0);
            end else begin
                if (rc == 0) m_rx = 0;
                else if (rx_trig_hit || rx_timeout) m_rx = 1;
                if (tc == 0) m_tx = 1;
                else if (tc >= DEPTH) m_tx = 0;
            end
            m_multi_last = multi;
        end
    end

    task automatic cmp(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // drive at negedge, let one edge pass, compare at next negedge
    task automatic cyc(int rc, bit tg, bit to, int tc);
        rx_count = CW'(rc); rx_trig_hit = tg; rx_timeout = to; tx_count = CW'(tc);
        @(posedge clk); @(negedge clk);
        cfg_wr = 1'b0;
        cmp(m_multi_last ? "R5 rx model" : "R3 rx model", rx_rdy_n, ~m_rx);
        cmp(m_multi_last ? "R7 tx model" : "R6 tx model", tx_rdy_n, ~m_tx);
    endtask

    task automatic set_cfg(bit fe, bit sl);
        cfg_wr = 1'b1; cfg_fifo_on = fe; cfg_multi_sel = sl;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        cmp("R1 reset rx", rx_rdy_n, 1'b1);
        cmp("R1 reset tx", tx_rdy_n, 1'b1);
        rst = 1'b0;
        cyc(0, 0, 0, 3);
        cmp("R1 rx idle after reset", rx_rdy_n, 1'b1);

        // legacy mode, select bit set but ignored
        set_cfg(0, 1);
        cyc(1, 0, 0, 1);
        cmp("R2 legacy rx single", rx_rdy_n, 1'b0);
        cmp("R2 legacy tx full at one", tx_rdy_n, 1'b1);
        cyc(0, 0, 0, 0);
        cmp("R2 legacy rx empty", rx_rdy_n, 1'b1);
        cmp("R8 legacy tx empty asks", tx_rdy_n, 1'b0);

        // FIFO on, single transfer
        set_cfg(1, 0);
        cyc(3, 0, 0, 5);
        cmp("R3 rx nonzero", rx_rdy_n, 1'b0);
        cmp("R6 tx nonzero", tx_rdy_n, 1'b1);
        cyc(0, 1, 1, 0);
        cmp("R3 rx empty", rx_rdy_n, 1'b1);
        cmp("R6 tx empty", tx_rdy_n, 1'b0);

        // multi transfer
        set_cfg(1, 1);
        cyc(4, 0, 0, 0);
        cmp("R9 multi no event", rx_rdy_n, 1'b1);
        cmp("R7 tx empty starts", tx_rdy_n, 1'b0);
        cyc(0, 1, 0, 7);
        cmp("R5 zero beats trigger", rx_rdy_n, 1'b1);
        cmp("R7 tx partial holds low", tx_rdy_n, 1'b0);
        cyc(6, 1, 0, DEPTH);
        cmp("R4 trigger starts", rx_rdy_n, 1'b0);
        cmp("R7 tx full stops", tx_rdy_n, 1'b1);
        cyc(2, 0, 0, 9);
        cmp("R5 hold without flags", rx_rdy_n, 1'b0);
        cmp("R7 tx partial holds high", tx_rdy_n, 1'b1);
        cyc(1, 0, 0, 9);
        cmp("R5 hold at one", rx_rdy_n, 1'b0);
        cyc(0, 0, 0, 9);
        cmp("R5 drained", rx_rdy_n, 1'b1);
        cyc(2, 0, 1, 9);
        cmp("R4 timeout starts", rx_rdy_n, 1'b0);

        // rewrite same multi mode mid-hold: requests restart released
        set_cfg(1, 1);
        cyc(2, 0, 0, 9);
        cmp("R9 reeval rx released", rx_rdy_n, 1'b1);
        cmp("R9 reeval tx released", tx_rdy_n, 1'b1);
        cyc(2, 1, 0, 0);
        set_cfg(1, 0);
        cyc(2, 0, 0, 4);
        cmp("R8 back to single rx", rx_rdy_n, 1'b0);
        cmp("R8 back to single tx", tx_rdy_n, 1'b1);

        // mixed random traffic in each mode
        for (int ph = 0; ph < 4; ph++) begin
            set_cfg(ph[0] | ph[1], ph[1]);
            for (int k = 0; k < 300; k++) begin
                int lim;
                lim = (ph == 0) ? 1 : DEPTH;
                cyc(int'($urandom_range(lim, 0)), 1'($urandom_range(3, 0) == 0),
                    1'($urandom_range(7, 0) == 0), int'($urandom_range(lim, 0)));
            end
        end

        rst = 1'b1;
        cyc(5, 1, 0, 5);
        cmp("R1 reset again rx", rx_rdy_n, 1'b1);
        cmp("R1 reset again tx", tx_rdy_n, 1'b1);
        rst = 1'b0;
        set_cfg(0, 1);
        cyc(3, 1, 1, 0);
        cmp("R1 mode0 after reset", rx_rdy_n, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule